// File: doc/BRIEF.md
# Level-2 Local Alias and SRAM/Cache Partition Decoder

This block sits in front of one processor core's private 1024KB level-2 memory. Each address the core or another master issues is examined once, without waiting on a clock. When the owning core uses the short local alias, whose top byte is zero, the block rewrites the address into the core's per-core global form. When the request carries that global form already, it passes through unchanged. Any other address gets an out-of-range flag.

For each access that lands in the memory, the block also reports which of two parts it hits. One part is plain SRAM that can be addressed directly. The other is the part held back for a 4-way set-associative cache. A 3-bit mode register, written by software through a write-enable and data port and readable back, sets the size of the cache part. The cache part always sits at the top of the 1024KB window, so raising the mode moves the SRAM/cache boundary down in power-of-two steps. The cache lookup itself is done elsewhere. Here only the region flag is produced.

Top module: `l2_alias_decoder`

## Requirements
- R1: The memory window is byte offsets 0x0080_0000 to 0x008F_FFFF within bits [23:0], so bits [23:20] equal 4'h8. When req_from_owner is 1, bits [31:24] are 8'h00 and the address falls in the window, the request is a hit. glb_addr is then {4'h1, core_idx, req_addr[23:0]}.
- R2: A request whose top byte is 8'h00 from a master other than the owner (req_from_owner = 0) gets out_of_range = 1 and is never a hit. glb_addr equals req_addr.
- R3: A request whose top byte equals {4'h1, core_idx} and whose address falls in the window is a hit from any master. glb_addr equals req_addr.
- R4: Every other address gets out_of_range = 1 and glb_addr equal to req_addr. This covers any other top byte, including another core's global top byte, and any owner alias outside the window.
- R5: After reset, cfg_rdata reads 3'b000. In this mode every hit is an SRAM hit and cache_hit stays 0.
- R6: Modes 3'b001 to 3'b101 set the cache part to 32KB, 64KB, 128KB, 256KB and 512KB in that order, placed at the top of the window. For example, mode 3'b010 gives cache for offsets 0x8F_0000 and above and SRAM below that.
- R7: Modes 3'b110 and 3'b111 make the whole window cache, so every hit is a cache hit.
- R8: When cfg_we is high at a clock edge, cfg_wdata is stored. It shows on cfg_rdata and takes effect on the decode from the next cycle. When cfg_we is low, the mode holds.
- R9: For every request, exactly one of sram_hit, cache_hit and out_of_range is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 32 | Request address |
| req_from_owner | input | 1 | Request issued by the core that owns this memory |
| core_idx | input | 4 | Index of the owning core |
| cfg_we | input | 1 | Mode register write enable |
| cfg_wdata | input | 3 | Mode register write data |
| cfg_rdata | output | 3 | Mode register read-back |
| glb_addr | output | 32 | Global address after alias expansion |
| sram_hit | output | 1 | Access hits the SRAM part |
| cache_hit | output | 1 | Access hits the cache part |
| out_of_range | output | 1 | Access is not for this memory |

## Verification
Address patterns are applied for the owner and for a foreign master, and each is tried in local-alias form, in global form, with another core's global top byte, and outside the window. Together these separate correct alias expansion from pass-through and from rejection. Every mode is then probed at the byte just below and exactly at its SRAM/cache boundary, and at the lowest and highest window offsets. This exposes an off-by-one boundary or a swapped encoding. Mode writes are checked on the cycle after the write, and with the enable held low, to show when a change takes effect and that the mode holds.

// File: rtl/l2dec_pkg.sv
package l2dec_pkg;
  localparam int ADDR_W         = 32;
  localparam int CORE_W         = 4;
  localparam int MODE_W         = 3;
  localparam int L2_LOG2        = 20;          // 1024KB window
  localparam int CACHE_MIN_LOG2 = 15;          // smallest cache part, 32KB
  localparam int SPLIT_MODES    = 5;           // modes 1..5 carry a split
  localparam logic [3:0] GLB_NIBBLE = 4'h1;
  localparam logic [3:0] WIN_SEL    = 4'h8;    // bits [23:20] of the window

  typedef enum logic [1:0] {
    CLS_SRAM  = 2'd0,
    CLS_CACHE = 2'd1,
    CLS_NONE  = 2'd2
  } region_e;
endpackage

// File: rtl/l2_mode_reg.sv
module l2_mode_reg #(
  parameter int MODE_W = l2dec_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/l2_alias_xlate.sv
module l2_alias_xlate #(
  parameter int ADDR_W = l2dec_pkg::ADDR_W,
  parameter int CORE_W = l2dec_pkg::CORE_W,
  parameter int L2_LOG2 = l2dec_pkg::L2_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              from_owner,
  input  logic [CORE_W-1:0] core,
  output logic [ADDR_W-1:0] glb,
  output logic              hit
);
  localparam int LOW_W = ADDR_W - 8;
  localparam int WIN_W = LOW_W - L2_LOG2;

  logic [7:0]       top_byte;
  logic [7:0]       own_top;
  logic             in_window;
  logic             local_ok;
  logic             global_ok;

  always_comb begin
    top_byte  = addr[ADDR_W-1 -: 8];
    own_top   = {l2dec_pkg::GLB_NIBBLE, core};
    in_window = (addr[LOW_W-1 -: WIN_W] == l2dec_pkg::WIN_SEL[WIN_W-1:0]);
    local_ok  = from_owner && (top_byte == 8'h00) && in_window;
    global_ok = (top_byte == own_top) && in_window;
    hit       = local_ok || global_ok;
    glb       = local_ok ? {own_top, addr[LOW_W-1:0]} : addr;
  end
endmodule

// File: rtl/l2_part_class.sv
module l2_part_class #(
  parameter int L2_LOG2        = l2dec_pkg::L2_LOG2,
  parameter int CACHE_MIN_LOG2 = l2dec_pkg::CACHE_MIN_LOG2,
  parameter int SPLIT_MODES    = l2dec_pkg::SPLIT_MODES,
  parameter int MODE_W         = l2dec_pkg::MODE_W
) (
  input  logic [L2_LOG2-1:0] offset,
  input  logic [MODE_W-1:0]  mode,
  output logic               in_cache
);
  // top_hit[m] : offset lies in the top 2^(CACHE_MIN_LOG2+m-1) bytes
  logic [SPLIT_MODES:1] top_hit;

  genvar m;
  generate
    for (m = 1; m <= SPLIT_MODES; m++) begin : g_split
      localparam int K = CACHE_MIN_LOG2 + m - 1;
      assign top_hit[m] = &offset[L2_LOG2-1:K];
    end
  endgenerate

  always_comb begin
    if (mode == '0)
      in_cache = 1'b0;
    else if (int'(mode) > SPLIT_MODES)
      in_cache = 1'b1;
    else
      in_cache = top_hit[mode];
  end
endmodule

// File: rtl/l2_alias_decoder.sv
module l2_alias_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] req_addr,
  input  logic        req_from_owner,
  input  logic [3:0]  core_idx,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_wdata,
  output logic [2:0]  cfg_rdata,
  output logic [31:0] glb_addr,
  output logic        sram_hit,
  output logic        cache_hit,
  output logic        out_of_range
);
  import l2dec_pkg::*;

  logic        win_hit;
  logic        part_cache;
  logic [2:0]  mode_q;
  region_e     cls;

  l2_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .mode_q  (mode_q)
  );

  l2_alias_xlate #(.ADDR_W(ADDR_W), .CORE_W(CORE_W), .L2_LOG2(L2_LOG2)) u_xlate (
    .addr       (req_addr),
    .from_owner (req_from_owner),
    .core       (core_idx),
    .glb        (glb_addr),
    .hit        (win_hit)
  );

  l2_part_class #(
    .L2_LOG2(L2_LOG2), .CACHE_MIN_LOG2(CACHE_MIN_LOG2),
    .SPLIT_MODES(SPLIT_MODES), .MODE_W(MODE_W)
  ) u_part (
    .offset   (req_addr[L2_LOG2-1:0]),
    .mode     (mode_q),
    .in_cache (part_cache)
  );

  always_comb begin
    if (!win_hit)        cls = CLS_NONE;
    else if (part_cache) cls = CLS_CACHE;
    else                 cls = CLS_SRAM;
    sram_hit     = (cls == CLS_SRAM);
    cache_hit    = (cls == CLS_CACHE);
    out_of_range = (cls == CLS_NONE);
  end

  assign cfg_rdata = mode_q;
endmodule

// File: rtl/l2_alias_decoder_chk.sv
module l2_alias_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] req_addr,
  input logic        req_from_owner,
  input logic [3:0]  core_idx,
  input logic        cfg_we,
  input logic [2:0]  cfg_wdata,
  input logic [2:0]  cfg_rdata,
  input logic [31:0] glb_addr,
  input logic        sram_hit,
  input logic        cache_hit,
  input logic        out_of_range
);
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sram_hit, cache_hit, out_of_range}) == 1); // R9

  AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[31:24] == 8'h00 && !req_from_owner) |-> out_of_range); // R2

  AST_LOCAL_EXPAND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[31:24] == 8'h00 && req_from_owner && !out_of_range)
      |-> glb_addr[31:24] == {4'h1, core_idx}); // R1

  AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R8

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata)); // R8

  AST_MODE0_NO_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata == 3'b000 |-> !cache_hit); // R5

  AST_FULL_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2:1] == 2'b11 |-> !sram_hit); // R7
endmodule

bind l2_alias_decoder l2_alias_decoder_chk u_chk (.*);

// File: tb/l2_alias_decoder_tb_top.sv
module l2_alias_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] req_addr;
  logic        req_from_owner;
  logic [3:0]  core_idx;
  logic        cfg_we;
  logic [2:0]  cfg_wdata;
  logic [2:0]  cfg_rdata;
  logic [31:0] glb_addr;
  logic        sram_hit, cache_hit, out_of_range;

  int n_run  = 0;
  int n_fail = 0;
  logic [2:0] cur_mode;
  bit done = 0;

  l2_alias_decoder dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // expected class: 0 sram, 1 cache, 2 out of range
  function automatic int exp_cls(logic [31:0] a, logic own, logic [3:0] c, logic [2:0] md);
    logic hit;
    int   cache_bytes;
    hit = ((a[31:24] == 8'h00 && own) || a[31:24] == {4'h1, c}) && a[23:20] == 4'h8;
    if (!hit) return 2;
    case (md)
      3'd0: cache_bytes = 0;
      3'd1: cache_bytes = 32 * 1024;
      3'd2: cache_bytes = 64 * 1024;
      3'd3: cache_bytes = 128 * 1024;
      3'd4: cache_bytes = 256 * 1024;
      3'd5: cache_bytes = 512 * 1024;
      default: cache_bytes = 1024 * 1024;
    endcase
    if (int'(a[19:0]) >= 1024 * 1024 - cache_bytes) return 1;
    return 0;
  endfunction

  task automatic probe(string req, logic [31:0] a, logic own, logic [3:0] c);
    int cls_e, cls_a;
    logic [31:0] g_e;
    req_addr = a; req_from_owner = own; core_idx = c;
    #1;
    cls_e = exp_cls(a, own, c, cur_mode);
    g_e = (a[31:24] == 8'h00 && own && a[23:20] == 4'h8) ? {4'h1, c, a[23:0]} : a;
    cls_a = sram_hit ? 0 : cache_hit ? 1 : out_of_range ? 2 : 3;
    n_run++;
    if ($countones({sram_hit, cache_hit, out_of_range}) != 1 || cls_a != cls_e || glb_addr !== g_e) begin
      n_fail++;
      $display("FAIL %s addr=%h own=%0d core=%0d: class %0d glb %h, expected class %0d glb %h",
               req, a, own, c, cls_a, glb_addr, cls_e, g_e);
    end
  endtask

  task automatic check_mode(string req, logic [2:0] e);
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s cfg_rdata %0d, expected %0d", req, cfg_rdata, e);
    end
  endtask

  task automatic write_mode(logic [2:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_mode = m;
  endtask

  task automatic t_reset;
    check_mode("R5", 3'd0);
    probe("R5", 32'h008F_FFFF, 1'b1, 4'd0);
    probe("R5", 32'h1080_0000, 1'b0, 4'd0);
  endtask

  task automatic t_alias;
    probe("R1", 32'h0080_0000, 1'b1, 4'd0);
    probe("R1", 32'h0085_1234, 1'b1, 4'd2);
    probe("R1", 32'h008F_FFFC, 1'b1, 4'd7);
    probe("R2", 32'h0080_0000, 1'b0, 4'd0);
    probe("R2", 32'h0088_0010, 1'b0, 4'd3);
    probe("R3", 32'h1180_0040, 1'b0, 4'd1);
    probe("R3", 32'h128F_0000, 1'b1, 4'd2);
    probe("R4", 32'h1180_0000, 1'b0, 4'd0);
    probe("R4", 32'h0090_0000, 1'b1, 4'd0);
    probe("R4", 32'h007F_FFFF, 1'b1, 4'd0);
    probe("R4", 32'h2080_0000, 1'b1, 4'd0);
    probe("R4", 32'h1190_0000, 1'b0, 4'd1);
  endtask

  task automatic t_modes;
    for (int m = 1; m <= 5; m++) begin
      int bnd;
      write_mode(m[2:0]);
      check_mode("R8", m[2:0]);
      bnd = 1024 * 1024 - (32 * 1024 << (m - 1));
      probe("R6", 32'h0080_0000 + bnd - 1, 1'b1, 4'd1);
      probe("R6", 32'h0080_0000 + bnd,     1'b1, 4'd1);
      probe("R6", 32'h1080_0000 + bnd,     1'b0, 4'd0);
      probe("R6", 32'h0080_0000,           1'b1, 4'd1);
    end
    for (int m = 6; m <= 7; m++) begin
      write_mode(m[2:0]);
      probe("R7", 32'h0080_0000, 1'b1, 4'd0);
      probe("R7", 32'h108F_FFFF, 1'b0, 4'd0);
      probe("R7", 32'h0080_0000, 1'b0, 4'd0);
    end
  endtask

  task automatic t_hold;
    write_mode(3'd2);
    cfg_wdata = 3'd5;
    repeat (3) @(negedge clk);
    check_mode("R8", 3'd2);
    probe("R8", 32'h008E_FFFF, 1'b1, 4'd0);
    write_mode(3'd0);
    check_mode("R8", 3'd0);
    probe("R8", 32'h008F_FFFF, 1'b1, 4'd0);
    rst_n = 1'b0;
    write_mode(3'd4);
    cur_mode = 3'd0;
    check_mode("R5", 3'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cur_mode = '0;
    req_addr = '0; req_from_owner = 1'b0; core_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_alias;
    t_modes;
    t_hold;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule